// File: doc/BRIEF.md
# Split Divide-By-Two / Divide-By-Six Counter

This block is a four-bit counter made of two independent sections that share one clear. The low section is a single toggle stage that divides its count input by two. The high section is a three-bit stage that divides its own count input by six. It walks a six-state code in which bits 1 and 2 each run at one third of the input rate, and bit 3 is a square wave at one sixth of the input rate with equal high and low halves. Both sections count on falling edges of their count inputs. The block finds these edges by sampling the inputs on a single system clock, so the count inputs are ordinary data signals and never clocks.

The two sections have no internal link. To get a modulo-12 counter, the surrounding logic feeds output bit 0 back into the high section's count input and applies the counts to the low section. The outputs then run through counts 0 to 11, and bit 3 is a symmetric divide-by-twelve square wave. A clear acts only when both of its inputs are high. It forces all four outputs low at once, blocks counting while it is held, and releases in step with the system clock.

Top module: `div12_split_counter`

## Requirements
- R1: Each falling edge of `cnt0_in` inverts `q[0]`. A rising edge of `cnt0_in` leaves `q` unchanged.
- R2: On falling edges of `cnt1_in`, the field `q[3:1]` steps through the codes 000, 001, 010, 100, 101, 110 and then returns to 000. In these codes the left digit is `q[3]`.
- R3: After k falling edges of `cnt1_in` from a cleared state, `q[1]` is 1 exactly when k mod 3 = 1, `q[2]` is 1 exactly when k mod 3 = 2, and `q[3]` is 1 exactly when k mod 6 is 3, 4 or 5.
- R4: The clear takes effect only when `clr_a` and `clr_b` are both 1. With just one of them high, `q` holds its value and both sections keep counting.
- R5: While `rst_n` is 0, or while both clear inputs are high, `q` reads 0 without waiting for a clock edge, and falling edges on the count inputs are ignored. After release, counting resumes normally.
- R6: A falling edge on a count input shows up on `q` at the third rising edge of `clk` after the input falls, and not before.
- R7: Edges on `cnt0_in` never change `q[3:1]`, and edges on `cnt1_in` never change `q[0]`.
- R8: With `cnt1_in` driven from `q[0]` and counts applied to `cnt0_in`, `q` after n counts equals {h>=3, h mod 3 = 2, h mod 3 = 1, n mod 2}, where h = (n mod 12)/2. This makes `q[3]` low for counts 0 to 5 and high for counts 6 to 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for sampling and for all state |
| rst_n | input | 1 | Active-low system reset; clears the state and the samplers |
| cnt0_in | input | 1 | Count input of the divide-by-two section; counts on falling edges |
| cnt1_in | input | 1 | Count input of the divide-by-six section; counts on falling edges |
| clr_a | input | 1 | First leg of the two-input gated clear |
| clr_b | input | 1 | Second leg of the two-input gated clear |
| q | output | 4 | Counter outputs: bit 0 from the divide-by-two section, bits 3..1 from the divide-by-six section |

## Verification
A count-input edge takes three rising clock edges to reach `q`: two synchronizer stages and the state register. Every pulse in the bench therefore ends with the input falling on a clock falling edge and waits four falling edges before it samples `q`. The latency test samples one cycle early to confirm the old value, then samples on the due cycle to confirm the new one. The clear reaches `q` with no clock edge at all, so the bench samples it one time unit after driving. It waits three falling edges after release, covering the two-stage release, before it applies the next count.

// File: rtl/div12_pkg.sv
package div12_pkg;

  localparam int SIX_W = 3;

  typedef logic [SIX_W-1:0] six_code_t;

  // Six-state code: bit0 and bit1 form a one-hot-or-zero divide-by-three
  // ring, bit2 flips each time that ring wraps.
  localparam six_code_t SIX_ZERO = 3'b000;
  localparam six_code_t SIX_LAST = 3'b110;

  function automatic six_code_t six_next(input six_code_t cur);
    six_code_t nxt;
    unique case (cur[1:0])
      2'b00:   nxt = {cur[2], 2'b01};
      2'b01:   nxt = {cur[2], 2'b10};
      2'b10:   nxt = {~cur[2], 2'b00};
      default: nxt = SIX_ZERO;  // unused codes fall back to zero
    endcase
    return nxt;
  endfunction

  function automatic logic six_code_legal(input six_code_t cur);
    return cur[1:0] != 2'b11;
  endfunction

endpackage

// File: rtl/cnt_fall_detect.sv
module cnt_fall_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q[0] <= din;
      for (int i = 1; i < STAGES; i++) sync_q[i] <= sync_q[i-1];
      last_q <= sync_q[STAGES-1];
    end
  end

  assign fall = last_q & ~sync_q[STAGES-1];

  // A detected edge lasts exactly one cycle (supports R6 timing).
  p_fall_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);

endmodule

// File: rtl/clr_sync.sv
module clr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  output logic busy
);
  logic [STAGES-1:0] hold_q;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) hold_q <= '1;
    else begin
      hold_q[0] <= 1'b0;
      for (int i = 1; i < STAGES; i++) hold_q[i] <= hold_q[i-1];
    end
  end

  assign busy = hold_q[STAGES-1];

  // An active clear request is always seen as busy at the clock (R4/R5).
  p_req_busy_r4: assert property (@(posedge clk) arst |-> busy);

endmodule

// File: rtl/half_stage.sv
module half_stage (
  input  logic clk,
  input  logic clr,
  input  logic adv,
  output logic q
);
  always_ff @(posedge clk or posedge clr) begin
    if (clr)      q <= 1'b0;
    else if (adv) q <= ~q;
  end

  p_toggle_r1: assert property (@(posedge clk) disable iff (clr)
    adv |=> q != $past(q));
  p_hold_r1: assert property (@(posedge clk) disable iff (clr)
    !adv |=> $stable(q));

endmodule

// File: rtl/six_stage.sv
module six_stage
  import div12_pkg::*;
(
  input  logic      clk,
  input  logic      clr,
  input  logic      adv,
  output six_code_t code
);
  always_ff @(posedge clk or posedge clr) begin
    if (clr)      code <= SIX_ZERO;
    else if (adv) code <= six_next(code);
  end

  p_wrap_r2: assert property (@(posedge clk) disable iff (clr)
    adv && code == SIX_LAST |=> code == SIX_ZERO);
  p_legal_r2: assert property (@(posedge clk) disable iff (clr)
    six_code_legal(code));
  p_hold_r2: assert property (@(posedge clk) disable iff (clr)
    !adv |=> $stable(code));

endmodule

// File: rtl/div12_split_counter.sv
module div12_split_counter
  import div12_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CLR_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cnt0_in,
  input  logic       cnt1_in,
  input  logic       clr_a,
  input  logic       clr_b,
  output logic [3:0] q
);
  logic      clr_req;
  logic      clr_busy;
  logic      fall0;
  logic      fall1;
  logic      half_q;
  six_code_t six_q;

  assign clr_req = ~rst_n | (clr_a & clr_b);

  clr_sync #(.STAGES(CLR_STAGES)) u_clr (
    .clk  (clk),
    .arst (clr_req),
    .busy (clr_busy)
  );

  cnt_fall_detect #(.STAGES(SYNC_STAGES)) u_fall0 (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (cnt0_in),
    .fall (fall0)
  );

  cnt_fall_detect #(.STAGES(SYNC_STAGES)) u_fall1 (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (cnt1_in),
    .fall (fall1)
  );

  half_stage u_half (
    .clk(clk),
    .clr(clr_busy),
    .adv(fall0),
    .q  (half_q)
  );

  six_stage u_six (
    .clk (clk),
    .clr (clr_busy),
    .adv (fall1),
    .code(six_q)
  );

  assign q = {six_q, half_q};

  p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy |-> q == 4'd0);
  p_split_r7: assert property (@(posedge clk) disable iff (clr_busy)
    !fall1 |=> $stable(q[3:1]));

endmodule

// File: tb/sim_div12_split_counter.sv
module sim_div12_split_counter;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt0_in = 1'b0;
  logic       cnt1_in = 1'b0;
  logic       clr_a = 1'b0;
  logic       clr_b = 1'b0;
  logic [3:0] q;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  div12_split_counter u0 (
    .clk(clk), .rst_n(rst_n), .cnt0_in(cnt0_in), .cnt1_in(cnt1_in),
    .clr_a(clr_a), .clr_b(clr_b), .q(q)
  );

  // op in [5:4]: 0 = pulse cnt0_in, 1 = pulse cnt1_in; expected q in [3:0]
  localparam int NV = 10;
  localparam logic [5:0] VEC [NV] = '{
    {2'd1, 4'd2}, {2'd1, 4'd4}, {2'd1, 4'd8}, {2'd1, 4'd10},
    {2'd1, 4'd12}, {2'd1, 4'd0}, {2'd0, 4'd1}, {2'd1, 4'd3},
    {2'd0, 4'd2}, {2'd1, 4'd4}
  };

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: q=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic pulse0();
    @(negedge clk) cnt0_in = 1'b1;
    repeat (2) @(negedge clk);
    cnt0_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse1();
    @(negedge clk) cnt1_in = 1'b1;
    repeat (2) @(negedge clk);
    cnt1_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk) begin clr_a = 1'b1; clr_b = 1'b1; end
    repeat (2) @(negedge clk);
    clr_a = 1'b0; clr_b = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [3:0] m12(input int n);
    int h;
    int r;
    h = (n % 12) / 2;
    r = h % 3;
    return {h >= 3, r == 2, r == 1, (n % 2) == 1};
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: q=%b expected run to end", q);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset R5", q, 4'd0);

    // table walk: R2 sequence and R7 section independence
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][5:4] == 2'd0) pulse0();
      else pulse1();
      chk(i < 6 ? "R2 sequence" : "R7 independent", q, VEC[i][3:0]);
    end

    // R1 rising edge ignored, R6 latency
    @(negedge clk) cnt0_in = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 rising ignored", q, 4'd4);
    cnt0_in = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 not before third edge", q, 4'd4);
    @(negedge clk);
    chk("R6 on third edge", q, 4'd5);

    // R4 single clear leg has no effect
    clr_a = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 clr_a alone", q, 4'd5);
    clr_a = 1'b0; clr_b = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 clr_b alone", q, 4'd5);
    pulse1();
    chk("R4 counts with one leg", q, 4'd9);
    clr_b = 1'b0;

    // R5 clear immediate, overrides counting, resumes after release
    @(negedge clk) begin clr_a = 1'b1; clr_b = 1'b1; end
    #1;
    chk("R5 immediate clear", q, 4'd0);
    pulse0();
    pulse1();
    chk("R5 counts blocked", q, 4'd0);
    clr_a = 1'b0; clr_b = 1'b0;
    repeat (3) @(negedge clk);
    pulse0();
    chk("R5 resumes", q, 4'd1);

    // R3 divide ratios on bits 1..3
    do_clear();
    for (int k = 1; k <= 12; k++) begin
      pulse1();
      chk("R3 ratios", q, {(k % 6) >= 3, (k % 3) == 2, (k % 3) == 1, 1'b0});
    end

    // R8 chained modulo-12
    do_clear();
    cnt1_in = 1'b0;
    for (int n = 1; n <= 12; n++) begin
      pulse0();
      cnt1_in = q[0];
      repeat (4) @(negedge clk);
      chk("R8 modulo-12", q, m12(n));
      chk("R8 square wave bit", {3'b000, q[3]}, {3'b000, (n % 12) >= 6});
    end

    finish_run();
  end

endmodule